// File: doc/BRIEF.md
# Bus Target Decoder with Retry

This block is the host-facing front end of a target-only pass-through path on a PCI-style multiplexed address/data bus. It watches for the start of each bus transaction. On that cycle it captures the address and the command. It checks the command against the read and write commands it serves. It compares the address with up to four configurable windows. When both match, the block claims the cycle by asserting device-select.

A claimed cycle takes one of two paths, chosen by the downstream `busy` input. If the downstream logic is still finishing an earlier access, the initiator gets a target retry and the block goes back to idle. Otherwise the access is handed to the add-on side. The block raises a transfer-active flag and reports the window number, the direction and the single/burst type. It latches the address for readback. Each data phase is closed with the add-on's `done` strobe.

Top module: `bus_claim_front`

## Requirements
- R1: While reset is high and on the first cycle after it, `devsel_n`, `trdy_n` and `stop_n` are 1, `xfer_active` and `xfer_burst` are 0, `addr_hold` is 0 and `xfer_be_n` is 4'hF.
- R2: A transaction starts at a clock edge where `frame_n` is 0 and was 1 at the previous edge, while the block is idle. The block claims it only when `cbe_n` is 4'b0010, 4'b0011, 4'b0110 or 4'b0111 at that edge and the address hits a window. A claimed cycle drives `devsel_n` low from the next cycle. An unclaimed cycle leaves every output unchanged.
- R3: Window i hits when `cfg_en[i]` is 1 and `((ad_in ^ base_i) & mask_i) == 0`. Here base_i and mask_i are bits [32*i+31:32*i] of `cfg_base` and `cfg_mask`. When several windows hit, the lowest index wins and is shown on `xfer_region`.
- R4: A claimed cycle with `busy` at 1 at the start edge is retried. `devsel_n` and `stop_n` are 0, `trdy_n` is 1 and `xfer_active` is 0 from the next cycle. This holds until an edge where `frame_n` is 1, after which `devsel_n` and `stop_n` return to 1.
- R5: A claimed cycle with `busy` at 0 is accepted. From the next cycle `xfer_active` is 1, `xfer_write` equals bit 0 of the command and `addr_hold` holds the start-edge address.
- R6: `addr_hold` changes only when a cycle is accepted. Retried and unclaimed cycles leave it as it was.
- R7: `xfer_burst` becomes 1 after the first edge following acceptance if `frame_n` is 0 at that edge. It stays 0 for a single-data-phase access and returns to 0 when the transfer ends.
- R8: In a transfer, `done` at 1 while `trdy_n` is 1 drives `trdy_n` to 0 at the next cycle. A data phase completes at an edge where `trdy_n` and `irdy_n` are both 0, and `trdy_n` then returns to 1. If `frame_n` is 1 at that edge, `devsel_n` goes to 1 and `xfer_active` goes to 0.
- R9: During a transfer, `xfer_be_n` shows the `cbe_n` value sampled at the previous edge. It is 4'hF once the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command (start edge) or byte enables (data phases) |
| cfg_base | input | 128 | Four window base addresses, window 0 in the low bits |
| cfg_mask | input | 128 | Four window compare masks, 1 = bit compared |
| cfg_en | input | 4 | Per-window enable |
| busy | input | 1 | Downstream still finishing an earlier access |
| done | input | 1 | Add-on has finished the current data phase |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| xfer_active | output | 1 | Pass-through access in progress |
| xfer_burst | output | 1 | Access has more than one data phase |
| xfer_region | output | 2 | Index of the decoded window |
| xfer_write | output | 1 | 1 for a write, 0 for a read |
| xfer_be_n | output | 4 | Byte enables of the current data phase, active low |
| addr_hold | output | 32 | Address of the last accepted access |

## Verification
The hardest case to reach is a retry. It needs a command and address that the block would otherwise accept, arriving at the very edge where downstream reports busy. A retried cycle must also leave the stored address untouched. The bench drives `busy` directly and sweeps it against every command code and a set of addresses. The addresses sit at window edges, in overlapping windows, in a disabled window and in gaps. Every pairing therefore reaches the retry path, the accept path and the ignore path. Accepted cycles alternate among one, two and three data phases to cover both single and burst marking.

// File: rtl/claim_pkg.sv
package claim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RETRY = 2'd1,
    ST_XFER  = 2'd2
  } tgt_state_t;

  // command groups served (upper three bits of the start-edge code)
  localparam logic [2:0] GRP_IO  = 3'b001;
  localparam logic [2:0] GRP_MEM = 3'b011;

  localparam logic [3:0] BE_NONE = 4'hF;

endpackage

// File: rtl/claim_cmd_decode.sv
module claim_cmd_decode
  import claim_pkg::*;
(
  input  logic [3:0] cmd,
  output logic       serve,
  output logic       is_write
);

  always_comb begin
    serve    = (cmd[3:1] == GRP_IO) || (cmd[3:1] == GRP_MEM);
    is_write = cmd[0];
  end

endmodule

// File: rtl/claim_region_match.sv
module claim_region_match #(
  parameter int AW   = 32,
  parameter int NREG = 4,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [AW-1:0]      addr,
  input  logic [NREG*AW-1:0] base,
  input  logic [NREG*AW-1:0] mask,
  input  logic [NREG-1:0]    en,
  output logic               hit,
  output logic [RW-1:0]      idx
);

  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic [AW-1:0] diff;
    always_comb begin
      diff     = (addr ^ base[g*AW +: AW]) & mask[g*AW +: AW];
      match[g] = en[g] && (diff == '0);
    end
  end

  // lowest index has priority: scan downward so it is assigned last
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = RW'(i);
      end
    end
  end

endmodule

// File: rtl/claim_tgt_fsm.sv
module claim_tgt_fsm
  import claim_pkg::*;
#(
  parameter int RW = 2,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          claim,
  input  logic          busy,
  input  logic [RW-1:0] region_in,
  input  logic          write_in,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [BW-1:0] cbe_n,
  input  logic          done,
  output logic          take,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          xfer_active,
  output logic          xfer_burst,
  output logic [RW-1:0] xfer_region,
  output logic          xfer_write,
  output logic [BW-1:0] xfer_be_n
);

  tgt_state_t state;
  logic       first;

  always_comb take = (state == ST_IDLE) && start && claim && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      first       <= 1'b0;
      devsel_n    <= 1'b1;
      trdy_n      <= 1'b1;
      stop_n      <= 1'b1;
      xfer_active <= 1'b0;
      xfer_burst  <= 1'b0;
      xfer_region <= '0;
      xfer_write  <= 1'b0;
      xfer_be_n   <= {BW{1'b1}};
    end else begin
      case (state)
        ST_IDLE: begin
          if (start && claim) begin
            devsel_n <= 1'b0;
            if (busy) begin
              state  <= ST_RETRY;
              stop_n <= 1'b0;
            end else begin
              state       <= ST_XFER;
              xfer_active <= 1'b1;
              xfer_region <= region_in;
              xfer_write  <= write_in;
              xfer_burst  <= 1'b0;
              first       <= 1'b1;
            end
          end
        end
        ST_RETRY: begin
          if (frame_n) begin
            state    <= ST_IDLE;
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
          end
        end
        ST_XFER: begin
          first     <= 1'b0;
          xfer_be_n <= cbe_n;
          if (first && !frame_n) xfer_burst <= 1'b1;
          if (trdy_n) begin
            if (done) trdy_n <= 1'b0;
          end else if (!irdy_n) begin
            trdy_n <= 1'b1;
            if (frame_n) begin
              state       <= ST_IDLE;
              devsel_n    <= 1'b1;
              xfer_active <= 1'b0;
              xfer_burst  <= 1'b0;
              xfer_be_n   <= {BW{1'b1}};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_claim_front.sv
module bus_claim_front
  import claim_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter int BW   = 4,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [AW-1:0]      ad_in,
  input  logic [BW-1:0]      cbe_n,
  input  logic [NREG*AW-1:0] cfg_base,
  input  logic [NREG*AW-1:0] cfg_mask,
  input  logic [NREG-1:0]    cfg_en,
  input  logic               busy,
  input  logic               done,
  output logic               devsel_n,
  output logic               trdy_n,
  output logic               stop_n,
  output logic               xfer_active,
  output logic               xfer_burst,
  output logic [RW-1:0]      xfer_region,
  output logic               xfer_write,
  output logic [BW-1:0]      xfer_be_n,
  output logic [AW-1:0]      addr_hold
);

  logic          frame_q;
  logic          start;
  logic          win_hit;
  logic [RW-1:0] win_idx;
  logic          cmd_ok;
  logic          cmd_wr;
  logic          take;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= frame_n;
  end

  always_comb start = frame_q && !frame_n;

  claim_region_match #(.AW(AW), .NREG(NREG)) u_match (
    .addr (ad_in),
    .base (cfg_base),
    .mask (cfg_mask),
    .en   (cfg_en),
    .hit  (win_hit),
    .idx  (win_idx)
  );

  claim_cmd_decode u_cmd (
    .cmd      (cbe_n[3:0]),
    .serve    (cmd_ok),
    .is_write (cmd_wr)
  );

  claim_tgt_fsm #(.RW(RW), .BW(BW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .claim       (win_hit && cmd_ok),
    .busy        (busy),
    .region_in   (win_idx),
    .write_in    (cmd_wr),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .cbe_n       (cbe_n),
    .done        (done),
    .take        (take),
    .devsel_n    (devsel_n),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .xfer_active (xfer_active),
    .xfer_burst  (xfer_burst),
    .xfer_region (xfer_region),
    .xfer_write  (xfer_write),
    .xfer_be_n   (xfer_be_n)
  );

  always_ff @(posedge clk) begin
    if (rst)       addr_hold <= '0;
    else if (take) addr_hold <= ad_in;
  end

endmodule

// File: rtl/bus_claim_front_chk.sv
module bus_claim_front_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_n,
  input logic [AW-1:0] ad_in,
  input logic          devsel_n,
  input logic          trdy_n,
  input logic          stop_n,
  input logic          xfer_active,
  input logic          xfer_burst,
  input logic [AW-1:0] addr_hold
);

  // R2: a claim only follows an edge where frame was asserted
  a_r2_claim_after_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> $past(!frame_n));

  // R4: a retry never signals ready and never hands off
  a_r4_retry_not_ready: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> (trdy_n && !xfer_active && !devsel_n));

  // R5: a hand-off captures the start-edge address
  a_r5_addr_captured: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_active) |-> (addr_hold == $past(ad_in)));

  // R6: the stored address moves only with a hand-off
  a_r6_addr_only_on_take: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_hold) |-> $rose(xfer_active));

  // R8: target ready only inside a claimed cycle
  a_r8_ready_needs_select: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);

  // R7: burst marking only during a transfer
  a_r7_burst_in_xfer: assert property (@(posedge clk) disable iff (rst)
    xfer_burst |-> xfer_active);

endmodule

bind bus_claim_front bus_claim_front_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_n     (frame_n),
  .ad_in       (ad_in),
  .devsel_n    (devsel_n),
  .trdy_n      (trdy_n),
  .stop_n      (stop_n),
  .xfer_active (xfer_active),
  .xfer_burst  (xfer_burst),
  .addr_hold   (addr_hold)
);

// File: tb/bus_claim_front_bench.sv
module bus_claim_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NREG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, busy = 1'b0, done = 1'b0;
  logic [AW-1:0] ad_in = '0;
  logic [3:0] cbe_n = 4'hF;
  logic [NREG*AW-1:0] cfg_base, cfg_mask;
  logic [NREG-1:0] cfg_en;
  logic devsel_n, trdy_n, stop_n, xfer_active, xfer_burst, xfer_write;
  logic [1:0] xfer_region;
  logic [3:0] xfer_be_n;
  logic [AW-1:0] addr_hold;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] prev_addr = '0;

  logic [AW-1:0] wb [NREG];
  logic [AW-1:0] wm [NREG];
  logic          we [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_claim_front u_bus_claim_front (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
    .busy(busy), .done(done), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .xfer_active(xfer_active), .xfer_burst(xfer_burst),
    .xfer_region(xfer_region), .xfer_write(xfer_write), .xfer_be_n(xfer_be_n),
    .addr_hold(addr_hold)
  );

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // expected window decode: returns {hit, index}
  function automatic logic [2:0] exp_win(input logic [AW-1:0] a);
    for (int i = 0; i < NREG; i++)
      if (we[i] && (((a ^ wb[i]) & wm[i]) == '0)) return {1'b1, 2'(i)};
    return 3'b000;
  endfunction

  task automatic run(input logic [AW-1:0] a, input logic [3:0] cmd, input logic b, input int n);
    logic [2:0] w;
    logic served;
    logic [3:0] pat;
    w = exp_win(a);
    served = (cmd == 4'b0010) || (cmd == 4'b0011) || (cmd == 4'b0110) || (cmd == 4'b0111);
    @(negedge clk);
    frame_n = 1'b0; ad_in = a; cbe_n = cmd; busy = b; irdy_n = 1'b1; done = 1'b0;
    @(negedge clk);
    busy = 1'b0;
    if (!(served && w[2])) begin
      check("R2 unclaimed devsel", 32'(devsel_n), 32'd1);
      check("R6 unclaimed addr", addr_hold, prev_addr);
      frame_n = 1'b1;
      @(negedge clk);
      check("R2 unclaimed idle", 32'({devsel_n, stop_n, trdy_n, xfer_active}), 32'hE);
    end else if (b) begin
      check("R4 retry signals", 32'({devsel_n, stop_n, trdy_n, xfer_active}), 32'h2);
      check("R6 retry addr", addr_hold, prev_addr);
      frame_n = 1'b1; irdy_n = 1'b0;
      @(negedge clk);
      check("R4 retry release", 32'({devsel_n, stop_n}), 32'h3);
      irdy_n = 1'b1;
    end else begin
      check("R2 claim devsel", 32'(devsel_n), 32'd0);
      check("R3 region", 32'(xfer_region), 32'(w[1:0]));
      check("R5 active", 32'(xfer_active), 32'd1);
      check("R5 write", 32'(xfer_write), 32'(cmd[0]));
      check("R5 addr", addr_hold, a);
      prev_addr = a;
      for (int k = 0; k < n; k++) begin
        pat = cmd ^ 4'(k + 5);
        frame_n = (k == n - 1); irdy_n = 1'b0; cbe_n = pat; done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check("R8 ready", 32'(trdy_n), 32'd0);
        check("R9 byte enables", 32'(xfer_be_n), 32'(pat));
        if (k == 0) check("R7 burst", 32'(xfer_burst), 32'(n > 1));
        @(negedge clk);
        if (k < n - 1)
          check("R8 phase next", 32'({trdy_n, devsel_n, xfer_active}), 32'h5);
        else begin
          check("R8 end", 32'({trdy_n, devsel_n, xfer_active}), 32'h6);
          check("R7 burst cleared", 32'(xfer_burst), 32'd0);
          check("R9 be idle", 32'(xfer_be_n), 32'hF);
        end
      end
      frame_n = 1'b1; irdy_n = 1'b1;
    end
  endtask

  initial begin
    wb[0] = 32'h1000_0000; wm[0] = 32'hFFFF_F000; we[0] = 1'b1;
    wb[1] = 32'h2000_0000; wm[1] = 32'hFFFF_0000; we[1] = 1'b1;
    wb[2] = 32'h1000_0000; wm[2] = 32'hFF00_0000; we[2] = 1'b1;
    wb[3] = 32'h4000_0000; wm[3] = 32'hFFFF_0000; we[3] = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      cfg_base[i*AW +: AW] = wb[i];
      cfg_mask[i*AW +: AW] = wm[i];
      cfg_en[i] = we[i];
    end
  end

  logic [AW-1:0] addrs [9];
  initial begin
    addrs[0] = 32'h1000_0000; addrs[1] = 32'h1000_0FFC; addrs[2] = 32'h1000_1000;
    addrs[3] = 32'h10FF_FFFC; addrs[4] = 32'h1100_0000; addrs[5] = 32'h2000_ABC0;
    addrs[6] = 32'h2001_0000; addrs[7] = 32'h4000_0000; addrs[8] = 32'h0000_0000;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 32'({devsel_n, trdy_n, stop_n, xfer_active, xfer_burst}), 32'h1C);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 32'({devsel_n, trdy_n, stop_n, xfer_active, xfer_burst}), 32'h1C);
    check("R1 addr", addr_hold, 32'd0);
    check("R1 be", 32'(xfer_be_n), 32'hF);
    for (int ai = 0; ai < 9; ai++)
      for (int c = 0; c < 16; c++)
        for (int b = 0; b < 2; b++)
          run(addrs[ai], 4'(c), b[0], ((ai + c) % 3) + 1);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule